// File: doc/BRIEF.md
# Flash buffered-program command sequencer

This block sits between a host bus and the program engine of a NOR-style flash device. It watches host bus writes for the multi-cycle buffered-program command. That command has four parts: two unlock writes, a setup write that names a target block, and a word-count write. After that come one to thirty-two address/data loads and a confirm write. The loaded words are gathered into an internal write buffer that covers one 32-word aligned window of the array. When the confirm arrives, the whole buffer is offered to the program engine in parallel, together with the window base and a flag for each loaded slot.

Once programming has begun, every host read returns a status word instead of array data. While the engine is busy, a toggle bit in that word flips on each read. A good completion returns the block to read mode. A failed completion, or any violation of the command rules while loading, leaves the block in an error state. In that state reads keep returning status until a reset command is written. In read mode and during loading, reads pass the array's data through.

Top module: `fbuf_prog_seq`

## Requirements
- R1: The command starts only after two unlock writes: low data byte 0xAA with address bits 10..0 equal to 0x555, then 0x55 with bits 10..0 equal to 0x2AA. The next write must then carry 0x25, and it may go to any address; its address bits 22..16 name the target block. If any of these three writes has the wrong value or address, the block returns to read mode, and the writes that follow start no program.
- R2: If the word-count write carries a value N of 32 or more (N+1 words would exceed the 32-word buffer), the block enters the error state.
- R3: If the word-count write goes to an address whose bits 22..16 differ from the target block, the block enters the error state.
- R4: The first load must lie in the target block, and it fixes the window as address bits 22..5. If the first load lies outside the block, or a later load has bits 22..5 different from the window, the block enters the error state.
- R5: After N+1 loads, a write of 0x29 to an address in the target block starts programming. In the cycle after that write is captured, pg_start is high for exactly one cycle. At that point pg_win holds address bits 22..5 of the first load. pg_valid has a bit set for each slot loaded, where the slot is address bits 4..0. Slot k of pg_data (bits 16k+15..16k) holds the data last loaded to that slot.
- R6: If the write that follows the last load is not 0x29, or is not addressed inside the target block, the block enters the error state and no program starts.
- R7: Outside the busy and error states, a read returns on host_rdata, one cycle after host_rd, the value that arr_rdata had in the read cycle.
- R8: Status word encoding: bit 0 busy, bit 1 error, bit 2 toggle, all other bits 0. While busy, a read returns busy=1 and error=0, with the toggle bit inverting on each successive busy read (the first busy read after reset shows 0). Outside the busy state the toggle bit reads 0.
- R9: When the engine reports pg_done with pg_fail low, the block returns to read mode. With pg_fail high it enters the error state. Once in the error state, reads return 0x0002 and writes other than the reset code leave it there.
- R10: In the error state, a write with low data byte 0xF0 clears the error and returns the block to read mode.
- R11: While busy, host writes are ignored. No new program starts, and status reads continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host bus write strobe, one cycle per write |
| host_rd | input | 1 | Host bus read strobe, one cycle per read |
| host_addr | input | 23 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data: array data or status word |
| arr_rdata | input | 16 | Data from the array for the current read |
| pg_start | output | 1 | One-cycle request to the program engine |
| pg_win | output | 18 | Window base (address bits 22..5) of the buffer |
| pg_valid | output | 32 | Per-slot loaded flags |
| pg_data | output | 512 | Buffer contents, slot k in bits 16k+15..16k |
| pg_done | input | 1 | Engine completion pulse |
| pg_fail | input | 1 | Engine failure flag, qualified by pg_done |

## Verification
The case that is hardest to reach from the ports is the full 32-word buffer. It needs a count of 31, then thirty-one further loads that must all stay inside the window, then a confirm that lands exactly on the write after the last load. The bench therefore produces the loads in a loop from a window base and checks the whole valid mask and the top slot. The other case that needs care is the toggle sequence. Status reads are split across two program runs with an error in between, so the bench keeps its own toggle model across runs and checks that error-state reads never show the toggle bit.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_COUNT,
        S_LOAD0,
        S_LOADN,
        S_CONF,
        S_BUSY,
        S_ERR
    } seq_state_t;

    localparam logic [7:0]  KEY_A      = 8'hAA;
    localparam logic [7:0]  KEY_B      = 8'h55;
    localparam logic [10:0] KEY_A_ADDR = 11'h555;
    localparam logic [10:0] KEY_B_ADDR = 11'h2AA;
    localparam logic [7:0]  OP_SETUP   = 8'h25;
    localparam logic [7:0]  OP_CONFIRM = 8'h29;
    localparam logic [7:0]  OP_RESET   = 8'hF0;

    localparam int STB_BUSY = 0;
    localparam int STB_ERR  = 1;
    localparam int STB_TOG  = 2;

endpackage

// File: rtl/bp_cmd_fsm.sv
module bp_cmd_fsm
    import bp_pkg::*;
#(
    parameter int AW      = 23,
    parameter int DW      = 16,
    parameter int WORDS   = 32,
    parameter int BLK_LSB = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    input  logic                      pg_done,
    input  logic                      pg_fail,
    output seq_state_t                state_o,
    output logic                      start_o,
    output logic [AW-$clog2(WORDS)-1:0] win_o,
    output logic                      buf_clr,
    output logic                      buf_we,
    output logic [$clog2(WORDS)-1:0]  buf_idx,
    output logic [DW-1:0]             buf_data
);
    localparam int IW    = $clog2(WORDS);
    localparam int WIN_W = AW - IW;
    localparam int BLK_W = AW - BLK_LSB;

    typedef struct packed {
        seq_state_t       state;
        logic [BLK_W-1:0] blk;
        logic [WIN_W-1:0] win;
        logic [IW-1:0]    left;
        logic             start;
    } fsm_t;

    fsm_t r_q, r_d;
    logic blk_hit;

    always_comb begin
        r_d      = r_q;
        r_d.start = 1'b0;
        buf_clr  = 1'b0;
        buf_we   = 1'b0;
        buf_idx  = addr[IW-1:0];
        buf_data = wdata;
        blk_hit  = (addr[AW-1:BLK_LSB] == r_q.blk);
        case (r_q.state)
            S_READ: begin
                if (wr_en && wdata[7:0] == KEY_A && addr[10:0] == KEY_A_ADDR)
                    r_d.state = S_UNL1;
            end
            S_UNL1: begin
                if (wr_en)
                    r_d.state = (wdata[7:0] == KEY_B && addr[10:0] == KEY_B_ADDR)
                                ? S_UNL2 : S_READ;
            end
            S_UNL2: begin
                if (wr_en) begin
                    if (wdata[7:0] == OP_SETUP) begin
                        r_d.state = S_COUNT;
                        r_d.blk   = addr[AW-1:BLK_LSB];
                        buf_clr   = 1'b1;
                    end else begin
                        r_d.state = S_READ;
                    end
                end
            end
            S_COUNT: begin
                if (wr_en) begin
                    if (!blk_hit || wdata >= DW'(WORDS)) begin
                        r_d.state = S_ERR;
                    end else begin
                        r_d.left  = wdata[IW-1:0];
                        r_d.state = S_LOAD0;
                    end
                end
            end
            S_LOAD0: begin
                if (wr_en) begin
                    if (!blk_hit) begin
                        r_d.state = S_ERR;
                    end else begin
                        buf_we    = 1'b1;
                        r_d.win   = addr[AW-1:IW];
                        r_d.state = (r_q.left == '0) ? S_CONF : S_LOADN;
                    end
                end
            end
            S_LOADN: begin
                if (wr_en) begin
                    if (addr[AW-1:IW] != r_q.win) begin
                        r_d.state = S_ERR;
                    end else begin
                        buf_we   = 1'b1;
                        r_d.left = r_q.left - IW'(1);
                        if (r_q.left == IW'(1))
                            r_d.state = S_CONF;
                    end
                end
            end
            S_CONF: begin
                if (wr_en) begin
                    if (wdata[7:0] == OP_CONFIRM && blk_hit) begin
                        r_d.state = S_BUSY;
                        r_d.start = 1'b1;
                    end else begin
                        r_d.state = S_ERR;
                    end
                end
            end
            S_BUSY: begin
                if (pg_done)
                    r_d.state = pg_fail ? S_ERR : S_READ;
            end
            S_ERR: begin
                if (wr_en && wdata[7:0] == OP_RESET)
                    r_d.state = S_READ;
            end
            default: r_d.state = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_READ;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign start_o = r_q.start;
    assign win_o   = r_q.win;

endmodule

// File: rtl/bp_wbuf.sv
module bp_wbuf #(
    parameter int DW    = 16,
    parameter int WORDS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [DW-1:0]            wdata,
    output logic [WORDS*DW-1:0]      data_flat,
    output logic [WORDS-1:0]         valid
);
    typedef struct packed {
        logic [WORDS-1:0][DW-1:0] mem;
        logic [WORDS-1:0]         vld;
    } wbuf_t;

    wbuf_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr)
            r_d.vld = '0;
        if (we) begin
            r_d.mem[idx] = wdata;
            r_d.vld[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar k = 0; k < WORDS; k++) begin : g_slot
        assign data_flat[k*DW +: DW] = r_q.mem[k];
    end

    assign valid = r_q.vld;

endmodule

// File: rtl/bp_status.sv
module bp_status
    import bp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          busy,
    input  logic          err,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rdata,
    output logic          tog_o
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          tog;
    } stat_t;

    stat_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (rd_en) begin
            if (busy) begin
                r_d.rdata           = '0;
                r_d.rdata[STB_BUSY] = 1'b1;
                r_d.rdata[STB_TOG]  = r_q.tog;
                r_d.tog             = ~r_q.tog;
            end else if (err) begin
                r_d.rdata          = '0;
                r_d.rdata[STB_ERR] = 1'b1;
            end else begin
                r_d.rdata = arr_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
    assign tog_o = r_q.tog;

endmodule

// File: rtl/fbuf_prog_seq.sv
module fbuf_prog_seq
    import bp_pkg::*;
#(
    parameter int AW      = 23,
    parameter int DW      = 16,
    parameter int WORDS   = 32,
    parameter int BLK_LSB = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr,
    input  logic                          host_rd,
    input  logic [AW-1:0]                 host_addr,
    input  logic [DW-1:0]                 host_wdata,
    output logic [DW-1:0]                 host_rdata,
    input  logic [DW-1:0]                 arr_rdata,
    output logic                          pg_start,
    output logic [AW-$clog2(WORDS)-1:0]   pg_win,
    output logic [WORDS-1:0]              pg_valid,
    output logic [WORDS*DW-1:0]           pg_data,
    input  logic                          pg_done,
    input  logic                          pg_fail
);
    localparam int IW = $clog2(WORDS);

    seq_state_t     st;
    logic           tog;
    logic           buf_clr;
    logic           buf_we;
    logic [IW-1:0]  buf_idx;
    logic [DW-1:0]  buf_data;

    bp_cmd_fsm #(.AW(AW), .DW(DW), .WORDS(WORDS), .BLK_LSB(BLK_LSB)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .pg_done  (pg_done),
        .pg_fail  (pg_fail),
        .state_o  (st),
        .start_o  (pg_start),
        .win_o    (pg_win),
        .buf_clr  (buf_clr),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .buf_data (buf_data)
    );

    bp_wbuf #(.DW(DW), .WORDS(WORDS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .we        (buf_we),
        .idx       (buf_idx),
        .wdata     (buf_data),
        .data_flat (pg_data),
        .valid     (pg_valid)
    );

    bp_status #(.DW(DW)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (host_rd),
        .busy      (st == S_BUSY),
        .err       (st == S_ERR),
        .arr_rdata (arr_rdata),
        .rdata     (host_rdata),
        .tog_o     (tog)
    );

endmodule

// File: rtl/fbuf_prog_seq_chk.sv
module fbuf_prog_seq_chk
    import bp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int WORDS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] host_rdata,
    input  logic          pg_start,
    input  logic          pg_done,
    input  logic          pg_fail,
    input  seq_state_t    st,
    input  logic          tog
);

    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        pg_start |=> !pg_start);

    a_r5_start_after_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        pg_start |-> ($past(host_wr) && $past(host_wdata[7:0]) == OP_CONFIRM));

    a_r2_count_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_COUNT && host_wr && host_wdata >= DW'(WORDS)) |=> st == S_ERR);

    a_r8_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && st == S_BUSY) |=>
            (host_rdata[STB_BUSY] && !host_rdata[STB_ERR] && host_rdata[STB_TOG] == $past(tog)));

    a_r8_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && st == S_BUSY) |=> tog != $past(tog));

    a_r9_fail_to_err: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BUSY && pg_done && pg_fail) |=> st == S_ERR);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ERR && !(host_wr && host_wdata[7:0] == OP_RESET)) |=> st == S_ERR);

    a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ERR && host_wr && host_wdata[7:0] == OP_RESET) |=> st == S_READ);

    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BUSY && !pg_done) |=> (st == S_BUSY && !pg_start));

endmodule

bind fbuf_prog_seq fbuf_prog_seq_chk #(.DW(DW), .WORDS(WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .pg_start   (pg_start),
    .pg_done    (pg_done),
    .pg_fail    (pg_fail),
    .st         (st),
    .tog        (tog)
);

// File: tb/fbuf_prog_seq_tb_top.sv
module fbuf_prog_seq_tb_top;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [22:0]   host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic [15:0]   arr_rdata = '0;
    logic          pg_start;
    logic [17:0]   pg_win;
    logic [31:0]   pg_valid;
    logic [511:0]  pg_data;
    logic          pg_done = 1'b0;
    logic          pg_fail = 1'b0;

    int checks = 0;
    int fails  = 0;
    int starts = 0;
    bit tog    = 1'b0;
    bit fin    = 1'b0;
    bit rd_fl  = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    fbuf_prog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .arr_rdata(arr_rdata), .pg_start(pg_start), .pg_win(pg_win),
        .pg_valid(pg_valid), .pg_data(pg_data), .pg_done(pg_done), .pg_fail(pg_fail)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares each read result against the queued prediction
    always @(posedge clk) rd_fl <= host_rd;
    always @(negedge clk) begin
        if (pg_start) starts++;
        if (rd_fl) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard actual=%h expected=none", host_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {16'h0, host_rdata}, {16'h0, e});
            end
        end
    end

    task automatic wr(input logic [22:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] arr, input logic [15:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; arr_rdata = arr;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rd_busy(input string tag);
        rd(16'hDEAD, 16'h0001 | (16'(tog) << 2), tag);
        tog = ~tog;
    endtask

    task automatic unlock_setup(input logic [22:0] a);
        wr(23'h000555, 16'h00AA);
        wr(23'h0002AA, 16'h0055);
        wr(a, 16'h0025);
    endtask

    task automatic done(input logic f);
        @(negedge clk);
        pg_done = 1'b1; pg_fail = f;
        @(negedge clk);
        pg_done = 1'b0; pg_fail = 1'b0;
    endtask

    task automatic clear_err;
        wr(23'h000000, 16'h00F0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset rdata", {16'h0, host_rdata}, 32'h0);
        check("reset pg_start", {31'h0, pg_start}, 32'h0);
        check("reset pg_valid", pg_valid, 32'h0);

        // R7 array read in read mode
        rd(16'h1234, 16'h1234, "R7 idle read");

        // R5 three-word program
        unlock_setup(23'h03ABCD);
        wr(23'h030000, 16'd2);
        wr(23'h030045, 16'hA001);
        rd(16'h4321, 16'h4321, "R7 read while loading");
        wr(23'h030046, 16'hA002);
        wr(23'h03005F, 16'hA003);
        wr(23'h030010, 16'h0029);
        check("R5 pg_start", {31'h0, pg_start}, 32'h1);
        check("R5 pg_win", {14'h0, pg_win}, 32'h1802);
        check("R5 pg_valid", pg_valid, 32'h8000_0060);
        check("R5 slot5", {16'h0, pg_data[5*16 +: 16]}, 32'hA001);
        check("R5 slot31", {16'h0, pg_data[31*16 +: 16]}, 32'hA003);
        @(negedge clk);
        check("R5 pulse width", {31'h0, pg_start}, 32'h0);

        // R8 busy status and toggle, R11 writes ignored
        rd_busy("R8 busy read 1");
        rd_busy("R8 busy read 2");
        rd_busy("R8 busy read 3");
        s0 = starts;
        unlock_setup(23'h030000);
        wr(23'h030000, 16'd0);
        wr(23'h030000, 16'h0029);
        rd_busy("R11 still busy");
        check("R11 no new start", starts, s0);

        // R9 good completion returns to read mode
        done(1'b0);
        rd(16'h5A5A, 16'h5A5A, "R9 read after pass");

        // R9 failed completion, sticky error
        unlock_setup(23'h010000);
        wr(23'h010000, 16'd0);
        wr(23'h0100E3, 16'hBEEF);
        wr(23'h010000, 16'h0029);
        check("R5 single word valid", pg_valid, 32'h0000_0008);
        rd_busy("R8 busy read second run");
        done(1'b1);
        rd(16'h7777, 16'h0002, "R9 error status");
        wr(23'h000555, 16'h00AA);
        rd(16'h7777, 16'h0002, "R9 sticky after write");
        clear_err();
        rd(16'h6666, 16'h6666, "R10 read after reset code");

        // R1 bad unlock address: nothing starts
        s0 = starts;
        wr(23'h000555, 16'h00AA);
        wr(23'h0002AB, 16'h0055);
        wr(23'h020000, 16'h0025);
        wr(23'h020000, 16'd0);
        wr(23'h020001, 16'h1111);
        wr(23'h020000, 16'h0029);
        check("R1 bad unlock no start", starts, s0);
        rd(16'h0F0F, 16'h0F0F, "R1 still read mode");
        // R1 bad setup code
        wr(23'h000555, 16'h00AA);
        wr(23'h0002AA, 16'h0055);
        wr(23'h020000, 16'h0030);
        wr(23'h020000, 16'd0);
        wr(23'h020001, 16'h1111);
        wr(23'h020000, 16'h0029);
        check("R1 bad setup no start", starts, s0);

        // R2 count too large
        unlock_setup(23'h020000);
        wr(23'h020000, 16'd32);
        rd(16'h1111, 16'h0002, "R2 count 32 abort");
        clear_err();

        // R3 count to another block
        unlock_setup(23'h020000);
        wr(23'h040000, 16'd1);
        rd(16'h1111, 16'h0002, "R3 count wrong block");
        clear_err();

        // R4 first load outside block
        unlock_setup(23'h020000);
        wr(23'h020000, 16'd1);
        wr(23'h060005, 16'h2222);
        rd(16'h1111, 16'h0002, "R4 first load other block");
        clear_err();

        // R4 later load leaves window
        unlock_setup(23'h030000);
        wr(23'h030000, 16'd1);
        wr(23'h030045, 16'h3333);
        wr(23'h030065, 16'h3334);
        rd(16'h1111, 16'h0002, "R4 load outside window");
        clear_err();

        // R6 wrong confirm code and wrong confirm block
        unlock_setup(23'h030000);
        wr(23'h030000, 16'd0);
        wr(23'h030001, 16'h4444);
        wr(23'h030000, 16'h0030);
        rd(16'h1111, 16'h0002, "R6 bad confirm code");
        clear_err();
        unlock_setup(23'h030000);
        wr(23'h030000, 16'd0);
        wr(23'h030001, 16'h4444);
        wr(23'h050000, 16'h0029);
        rd(16'h1111, 16'h0002, "R6 confirm wrong block");
        clear_err();
        check("R6 no start", starts, s0);

        // R5 full 32-word buffer (count 31)
        unlock_setup(23'h050000);
        wr(23'h050000, 16'd31);
        for (int i = 0; i < 32; i++)
            wr(23'h050100 + 23'(i), 16'h1000 + 16'(i));
        wr(23'h050000, 16'h0029);
        check("R5 full pg_start", {31'h0, pg_start}, 32'h1);
        check("R5 full valid", pg_valid, 32'hFFFF_FFFF);
        check("R5 full win", {14'h0, pg_win}, 32'h2808);
        check("R5 full slot31", {16'h0, pg_data[31*16 +: 16]}, 32'h101F);
        check("R5 full slot0", {16'h0, pg_data[15:0]}, 32'h1000);
        rd_busy("R8 busy read full run");
        done(1'b0);
        rd(16'h9999, 16'h9999, "R9 pass after full");

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);
        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule